// File: doc/BRIEF.md
# Pipelined SRAM FIFO Controller

This controller turns an external synchronous pipelined SRAM into a single-clock first-in first-out queue. The SRAM needs no turnaround cycles between reads and writes. The controller runs on the memory clock. An internal phase counter divides that clock into periods of four cycles. In the last cycle of each period the controller raises `fifo_tick`. That strobe is the rate enable for the queue side: `push`, `pop` and `push_data` are sampled only while it is high.

Inside each period the controller gives the memory one write slot and one read slot. The write slot is the first cycle after the strobe, and the read slot is the third. The other two cycles leave the chip disabled. The SRAM expects write data two cycles after the write command, and it returns read data two cycles after the read command. Short shift pipelines line up the outgoing data, the bus output enable and the capture of incoming read data with those commands. The write address comes from a tail counter and the read address from a head counter, so the memory is used as a plain circular array. The bidirectional data pins appear here as three separate signals: data out, output enable and data in.

Top module: `zbt_fifo_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `empty`=1, `full`=0, `level`=0, `rd_valid`=0, `sram_ce_n`=1, `sram_we_n`=1 and `sram_dq_oe`=0.
- R2: `fifo_tick` is high in exactly one cycle of every four. Counting the first clock edge with `rst` low as edge 1, it is high after edges 3, 7, 11 and so on. `push`, `pop` and `push_data` are ignored in every other cycle.
- R3: A push accepted at a strobe puts a write command on the memory (`sram_ce_n`=0, `sram_we_n`=0) in the next cycle. Two cycles after that command, `sram_dq_oe`=1 and `sram_dq_o` carries the pushed word. In all other cycles `sram_dq_oe`=0.
- R4: A pop accepted at a strobe puts a read command (`sram_ce_n`=0, `sram_we_n`=1) on the memory three cycles after the strobe. `sram_dq_i` is captured two cycles after that command.
- R5: In every cycle that carries no issued access, `sram_ce_n`=1.
- R6: Write addresses follow a tail counter and read addresses follow a head counter. Each counter starts at 0, advances by one only when its access is issued, and wraps modulo 2^AW.
- R7: `rd_valid` is high for four cycles. It starts three cycles after the read command, so it is high at the second strobe after the accepted pop, and `rd_data` holds the popped word for that whole time. Words come out in push order.
- R8: At every strobe, `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` is 2^AW.
- R9: A push while `full` is ignored: no write command is issued and the word is not stored. A pop while `empty` is ignored: no read command is issued and `rd_valid` is not raised.
- R10: `level` changes only in the cycle after a strobe. It goes up by one for an accepted push alone and down by one for an accepted pop alone.
- R11: When a push and a pop are both accepted at the same strobe, both accesses are issued and `level` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_tick | output | 1 | Queue-rate strobe, one cycle in four |
| push | input | 1 | Push request, sampled at the strobe |
| push_data | input | DW | Word to push |
| pop | input | 1 | Pop request, sampled at the strobe |
| rd_data | output | DW | Popped word |
| rd_valid | output | 1 | `rd_data` holds a popped word |
| full | output | 1 | Queue holds 2^AW words |
| empty | output | 1 | Queue holds no words |
| level | output | AW+1 | Occupancy |
| sram_addr | output | AW | Memory address |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_dq_o | output | DW | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | DW | Data returned by the memory |

## Verification
Take the strobe cycle as time 0. The write command is due at +1 and its data and output enable at +3. The read command is due at +3, the capture happens at +5, and `rd_valid` is high from +6 to +9. The new `level` appears at +1, so it is visible at the next strobe. The bench keeps its own cycle index from the release of reset and derives every expected memory-bus value for that exact cycle from a queue model. It compares the strobe, the chip enable, the address and the output enable on every clock. It compares flags, occupancy and read data at each strobe against the pop made two strobes earlier. A behavioural SRAM model in the bench applies the same two-cycle lag in both directions.

// File: rtl/zbt_fifo_pkg.sv
package zbt_fifo_pkg;

    // Position inside one queue-rate period; the value is the phase count.
    typedef enum logic [1:0] {
        SLOT_WRITE = 2'd0,   // write command on the bus
        SLOT_GAP0  = 2'd1,   // read command is loaded at the end of this cycle
        SLOT_READ  = 2'd2,   // read command on the bus
        SLOT_GAP1  = 2'd3    // queue-side strobe
    } slot_e;

endpackage

// File: rtl/zbt_slot_timer.sv
module zbt_slot_timer
    import zbt_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot,
    output logic  tick
);
    typedef struct packed {
        logic [1:0] phase;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d       = tmr_q;
        tmr_d.phase = tmr_q.phase + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign slot = slot_e'(tmr_q.phase);
    assign tick = (slot_e'(tmr_q.phase) == SLOT_GAP1);
endmodule

// File: rtl/zbt_fifo_ptrs.sv
module zbt_fifo_ptrs #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_adv,
    input  logic          rd_adv,
    input  logic          push_ok,
    input  logic          pop_ok,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full,
    output logic          empty,
    output logic [AW:0]   level
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [PW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_adv) ptr_d.wptr = ptr_q.wptr + 1'b1;
        if (rd_adv) ptr_d.rptr = ptr_q.rptr + 1'b1;
        if (push_ok && !pop_ok)      ptr_d.cnt = ptr_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) ptr_d.cnt = ptr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign waddr = ptr_q.wptr[AW-1:0];
    assign raddr = ptr_q.rptr[AW-1:0];
    assign empty = (ptr_q.wptr == ptr_q.rptr);
    assign full  = (ptr_q.wptr[AW-1:0] == ptr_q.rptr[AW-1:0]) &&
                   (ptr_q.wptr[AW] != ptr_q.rptr[AW]);
    assign level = ptr_q.cnt;
endmodule

// File: rtl/zbt_data_pipe.sv
module zbt_data_pipe #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cmd,
    input  logic          rd_cmd,
    input  logic [DW-1:0] wr_word,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic [DW-1:0] rd_word,
    output logic          rd_valid
);
    localparam int LAT  = 2;   // memory data lag in cycles
    localparam int HOLD = 4;   // cycles per queue-rate period

    typedef struct packed {
        logic [LAT-1:0]         wv;
        logic [LAT-1:0][DW-1:0] wd;
        logic [LAT-1:0]         rv;
        logic [DW-1:0]          rdat;
        logic                   rvld;
        logic [1:0]             hold;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        p_d.wv[0] = wr_cmd;
        p_d.wd[0] = wr_word;
        p_d.rv[0] = rd_cmd;
        for (int i = 1; i < LAT; i++) begin
            p_d.wv[i] = p_q.wv[i-1];
            p_d.wd[i] = p_q.wd[i-1];
            p_d.rv[i] = p_q.rv[i-1];
        end
        if (p_q.rv[LAT-1]) begin
            p_d.rdat = bus_in;
            p_d.rvld = 1'b1;
            p_d.hold = 2'(HOLD - 1);
        end else if (p_q.rvld) begin
            if (p_q.hold == 2'd0) p_d.rvld = 1'b0;
            else                  p_d.hold = p_q.hold - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign bus_out  = p_q.wd[LAT-1];
    assign bus_oe   = p_q.wv[LAT-1];
    assign rd_word  = p_q.rdat;
    assign rd_valid = p_q.rvld;
endmodule

// File: rtl/zbt_fifo_ctrl.sv
module zbt_fifo_ctrl
    import zbt_fifo_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic          fifo_tick,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          full,
    output logic          empty,
    output logic [AW:0]   level,
    output logic [AW-1:0] sram_addr,
    output logic          sram_we_n,
    output logic          sram_ce_n,
    output logic [DW-1:0] sram_dq_o,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_i
);
    typedef struct packed {
        logic          pop_pend;
        logic [DW-1:0] wbuf;
        logic [AW-1:0] addr;
        logic          we_n;
        logic          ce_n;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    slot_e slot;
    logic  tick;
    logic  push_ok, pop_ok, rd_issue;
    logic  [AW-1:0] waddr, raddr;

    zbt_slot_timer u_tmr (
        .clk  (clk),
        .rst  (rst),
        .slot (slot),
        .tick (tick)
    );

    zbt_fifo_ptrs #(.AW(AW)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .wr_adv  (push_ok),
        .rd_adv  (rd_issue),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .waddr   (waddr),
        .raddr   (raddr),
        .full    (full),
        .empty   (empty),
        .level   (level)
    );

    always_comb begin
        push_ok  = tick && push && !full;
        pop_ok   = tick && pop && !empty;
        rd_issue = (slot == SLOT_GAP0) && ctl_q.pop_pend;

        ctl_d      = ctl_q;
        ctl_d.ce_n = 1'b1;
        ctl_d.we_n = 1'b1;
        if (push_ok) begin
            ctl_d.wbuf = push_data;
            ctl_d.addr = waddr;
            ctl_d.ce_n = 1'b0;
            ctl_d.we_n = 1'b0;
        end
        if (pop_ok) ctl_d.pop_pend = 1'b1;
        if (rd_issue) begin
            ctl_d.addr     = raddr;
            ctl_d.ce_n     = 1'b0;
            ctl_d.pop_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            ctl_q.ce_n <= 1'b1;
            ctl_q.we_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    zbt_data_pipe #(.DW(DW)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .wr_cmd   (!ctl_q.ce_n && !ctl_q.we_n),
        .rd_cmd   (!ctl_q.ce_n && ctl_q.we_n),
        .wr_word  (ctl_q.wbuf),
        .bus_in   (sram_dq_i),
        .bus_out  (sram_dq_o),
        .bus_oe   (sram_dq_oe),
        .rd_word  (rd_data),
        .rd_valid (rd_valid)
    );

    assign fifo_tick = tick;
    assign sram_addr = ctl_q.addr;
    assign sram_we_n = ctl_q.we_n;
    assign sram_ce_n = ctl_q.ce_n;
endmodule

// File: rtl/zbt_fifo_ctrl_chk.sv
module zbt_fifo_ctrl_chk #(
    parameter int AW = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        fifo_tick,
    input logic        sram_ce_n,
    input logic        sram_we_n,
    input logic        sram_dq_oe,
    input logic        rd_valid,
    input logic        full,
    input logic        empty,
    input logic [AW:0] level
);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(1 << AW);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (sram_ce_n && sram_we_n && !sram_dq_oe && !rd_valid && level == '0));

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_tick |=> !fifo_tick);

    // R3
    write_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && !sram_we_n) |-> $past(fifo_tick));

    // R3
    write_data_lag_chk: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> $past(!sram_ce_n && !sram_we_n, 2));

    // R4
    read_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && sram_we_n) |-> $past(fifo_tick, 3));

    // R7
    read_valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(!sram_ce_n && sram_we_n, 3));

    // R8
    flag_level_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_tick |-> ((empty == (level == '0)) && (full == (level == FULL_LVL))));

    // R10
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(fifo_tick) |-> $stable(level));
endmodule

bind zbt_fifo_ctrl zbt_fifo_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_tick  (fifo_tick),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe),
    .rd_valid   (rd_valid),
    .full       (full),
    .empty      (empty),
    .level      (level)
);

// File: tb/tb_zbt_fifo_ctrl.sv
module tb_zbt_fifo_ctrl;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          fifo_tick, push, pop, rd_valid, full, empty;
    logic [DW-1:0] push_data, rd_data, sram_dq_o, sram_dq_i;
    logic [AW:0]   level;
    logic [AW-1:0] sram_addr;
    logic          sram_we_n, sram_ce_n, sram_dq_oe;

    always #2 clk = ~clk;

    zbt_fifo_ctrl #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .fifo_tick(fifo_tick), .push(push),
        .push_data(push_data), .pop(pop), .rd_data(rd_data), .rd_valid(rd_valid),
        .full(full), .empty(empty), .level(level), .sram_addr(sram_addr),
        .sram_we_n(sram_we_n), .sram_ce_n(sram_ce_n), .sram_dq_o(sram_dq_o),
        .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    // Behavioural pipelined SRAM: data follows the command by two cycles.
    logic [DW-1:0] mem [DEPTH];
    logic          p0_v, p0_rd, p1_v, p1_rd;
    logic [AW-1:0] p0_a, p1_a;

    always @(posedge clk) begin
        if (rst) begin
            p0_v <= 1'b0; p1_v <= 1'b0; p0_rd <= 1'b0; p1_rd <= 1'b0;
            p0_a <= '0;   p1_a <= '0;
        end else begin
            if (p1_v && !p1_rd && sram_dq_oe) mem[p1_a] <= sram_dq_o;
            p1_v <= p0_v; p1_rd <= p0_rd; p1_a <= p0_a;
            p0_v <= !sram_ce_n; p0_rd <= sram_we_n; p0_a <= sram_addr;
        end
    end
    assign sram_dq_i = (p1_v && p1_rd) ? mem[p1_a] : '0;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] q[$];
        int  k, wc, rc;
        int  exp_wr_k, exp_rd_k, rej_wr_k, rej_rd_k;
        logic [AW-1:0] exp_wr_a, exp_rd_a;
        logic [DW-1:0] wd, h1d, h2d;
        bit  h1v, h2v, both;
        bit  pu, po, pok, pook;
        logic [DW-1:0] nd;

        rst = 1'b1; push = 0; pop = 0; push_data = '0;
        k = 0; wc = 0; rc = 0;
        exp_wr_k = -10; exp_rd_k = -10; rej_wr_k = -10; rej_rd_k = -10;
        h1v = 0; h2v = 0; h1d = '0; h2d = '0; wd = '0; both = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(empty == 1'b1, "R1 empty", empty, 1);
        chk(full == 1'b0, "R1 full", full, 0);
        chk(level == 0, "R1 level", level, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(sram_ce_n && sram_we_n, "R1 ce/we", {sram_ce_n, sram_we_n}, 3);
        chk(sram_dq_oe == 1'b0, "R1 oe", sram_dq_oe, 0);
        rst = 1'b0;

        for (int n = 0; n < 880; n++) begin
            @(negedge clk);
            k++;
            chk(fifo_tick == (k % 4 == 3), "R2 tick", fifo_tick, (k % 4 == 3));
            if (k == exp_wr_k) begin
                chk(!sram_ce_n && !sram_we_n, "R3 write cmd", {sram_ce_n, sram_we_n}, 0);
                chk(sram_addr == exp_wr_a, "R6 write addr", sram_addr, exp_wr_a);
            end else if (k == exp_rd_k) begin
                chk(!sram_ce_n && sram_we_n, "R4 read cmd", {sram_ce_n, sram_we_n}, 1);
                chk(sram_addr == exp_rd_a, "R6 read addr", sram_addr, exp_rd_a);
            end else if (k == rej_wr_k || k == rej_rd_k) begin
                chk(sram_ce_n == 1'b1, "R9 ignored access", sram_ce_n, 1);
            end else begin
                chk(sram_ce_n == 1'b1, "R5 idle slot", sram_ce_n, 1);
            end
            if (k == exp_wr_k + 2) begin
                chk(sram_dq_oe == 1'b1, "R3 oe", sram_dq_oe, 1);
                chk(sram_dq_o == wd, "R3 data", sram_dq_o, wd);
            end else begin
                chk(sram_dq_oe == 1'b0, "R3 oe idle", sram_dq_oe, 0);
            end

            if (k % 4 == 3) begin
                chk(level == q.size(), both ? "R11 level" : "R10 level", level, q.size());
                chk(empty == (q.size() == 0), "R8 empty", empty, q.size() == 0);
                chk(full == (q.size() == DEPTH), "R8 full", full, q.size() == DEPTH);
                chk(rd_valid == h2v, "R7 rd_valid", rd_valid, h2v);
                if (h2v) chk(rd_data == h2d, "R7 rd_data", rd_data, h2d);
                h2v = h1v; h2d = h1d;

                if (k / 4 < 18)      begin pu = 1; po = 0; end
                else if (k / 4 < 20) begin pu = 1; po = 1; end
                else if (k / 4 < 40) begin pu = 0; po = 1; end
                else if (k / 4 < 42) begin pu = 1; po = 1; end
                else begin pu = bit'($urandom % 2); po = bit'($urandom % 2); end
                nd = DW'($urandom);

                pok  = pu && (q.size() < DEPTH);
                pook = po && (q.size() > 0);
                both = pok && pook;
                h1v  = pook;
                if (pook) begin
                    h1d = q.pop_front();
                    exp_rd_k = k + 3; exp_rd_a = AW'(rc); rc = (rc + 1) % DEPTH;
                end else if (po) rej_rd_k = k + 3;
                if (pok) begin
                    q.push_back(nd);
                    exp_wr_k = k + 1; exp_wr_a = AW'(wc); wd = nd; wc = (wc + 1) % DEPTH;
                end else if (pu) rej_wr_k = k + 1;
                push = pu; pop = po; push_data = nd;
            end else if (k / 4 >= 42) begin
                // R2: strobes outside the tick must be ignored
                push = bit'($urandom % 2); pop = bit'($urandom % 2);
                push_data = DW'($urandom);
            end else begin
                push = 0; pop = 0;
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule